// File: doc/BRIEF.md
# Frame-Synced Serial DAC Word Transmitter

This block sits on the host side of a link to a 10-bit serial voltage DAC that latches a 16-bit word framed by an active-low chip select and an active-low frame sync. When the host raises a start request with a code, a speed-select bit and a power-down bit, the block builds the word and drives chip select, frame sync, serial clock and serial data. Every edge is placed from a single system clock, and all interval lengths are parameters counted in system clock cycles.

The serial clock idles high, so the first transition inside a frame is always a falling edge, and the DAC samples on those falling edges. Data bits are launched on rising edges, which keeps each bit stable across the whole low phase that ends in its sampling edge. An optional byte-split mode models a host port that only moves 8 bits per write. In that mode the word goes out as two bytes inside one frame-sync-low window, with an idle-high pause between them. A one-cycle done pulse marks the end of the exchange. It comes once chip select has gone high again and the frame-sync high time has been met.

Top module: `dacfrm_tx`

## Requirements
- R1: While reset is high and in the cycle after it falls, cs_n_o, fs_o and sclk_o are 1, din_o is 0, and busy_o and done_o are 0.
- R2: A start request is taken only in a cycle where busy_o is 0. busy_o rises in the same cycle that cs_n_o falls. A request made while busy_o is 1 starts no extra frame and does not change the word being sent.
- R3: The word goes out MSB first as 16 bits. Bit 15 is 0, bit 14 is the speed bit (1 selects fast), bit 13 is the power-down bit (1 selects power down), bit 12 is 0, bits 11..2 hold the 10-bit code and bits 1..0 are 0.
- R4: fs_o falls exactly CS_LEAD cycles after cs_n_o falls, and fs_o is only ever low while cs_n_o is low.
- R5: The first falling edge of sclk_o comes exactly FS_LEAD cycles after fs_o falls.
- R6: Each frame has exactly 16 falling edges of sclk_o. Each low phase and each high phase lasts HALF_CYC cycles, except the one high phase extended under R11. sclk_o stays high whenever fs_o is high.
- R7: din_o changes only at the cycle where sclk_o rises or where fs_o falls. It is therefore stable through every low phase of sclk_o.
- R8: fs_o rises exactly HALF_CYC cycles after the 16th rising edge of sclk_o. cs_n_o rises exactly FS_TAIL cycles after that, and fs_o is high when cs_n_o rises.
- R9: In byte-split mode, chosen by split_i at the accepted start, the high phase after the 8th falling edge lasts HALF_CYC + BYTE_GAP cycles. fs_o and cs_n_o stay low through that phase, and the upper byte goes first.
- R10: done_o is high for exactly one cycle, FS_REST cycles after cs_n_o rises. busy_o falls in that same cycle, and a start in that cycle is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Request to send one word |
| code_i | input | CODE_W | DAC code to send |
| fast_i | input | 1 | Speed bit: 1 fast settling, 0 slow |
| pdown_i | input | 1 | Power bit: 1 power down, 0 normal |
| split_i | input | 1 | 1 sends the word as two bytes with a pause |
| busy_o | output | 1 | Frame in progress |
| done_o | output | 1 | One-cycle end-of-exchange pulse |
| cs_n_o | output | 1 | Chip select, active low |
| fs_o | output | 1 | Frame sync, low during the frame |
| sclk_o | output | 1 | Serial clock, idles high |
| din_o | output | 1 | Serial data to the DAC |

## Verification
The done pulse and the acceptance of the next start can land in the same cycle. The bench provokes this on every other frame: it raises the next request in the cycle where done_o is seen. It then checks that chip select falls one cycle later and that the new frame still has its lead intervals intact. A request that arrives mid-frame is the other pairing of start and busy. It is injected with a different code on a regular stride. The bench judges it by the captured word on the pins and by the count of chip-select falls against the count of frames it expects.

// File: rtl/dacfrm_pkg.sv
package dacfrm_pkg;

  localparam int CTRL_BITS = 4;
  localparam int PAD_BITS  = 2;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CSL,
    ST_FSL,
    ST_LOW,
    ST_HIGH,
    ST_TAIL,
    ST_REST
  } dac_st_e;

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/dacfrm_word.sv
module dacfrm_word #(
  parameter int CODE_W = 10,
  parameter int WORD_W = 16,
  parameter int SW     = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [CODE_W-1:0] code,
  input  logic              fast,
  input  logic              pdown,
  input  logic [SW-1:0]     sel,
  output logic              bit_o
);
  import dacfrm_pkg::*;

  logic [WORD_W-1:0] word_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      word_q <= '0;
    end else if (load) begin
      word_q <= {1'b0, fast, pdown, 1'b0, code, {PAD_BITS{1'b0}}};
    end
  end

  // sel counts from the MSB; indices past the word read as zero
  always_comb begin
    bit_o = 1'b0;
    for (int k = 0; k < WORD_W; k++) begin
      if (sel == SW'(WORD_W - 1 - k)) bit_o = word_q[k];
    end
  end

endmodule

// File: rtl/dacfrm_timer.sv
module dacfrm_timer #(
  parameter int TW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [TW-1:0] val,
  output logic          zero_o
);
  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/dacfrm_fsm.sv
module dacfrm_fsm #(
  parameter int WORD_W   = 16,
  parameter int SW       = 5,
  parameter int TW       = 4,
  parameter int HALF_CYC = 2,
  parameter int CS_LEAD  = 1,
  parameter int FS_LEAD  = 1,
  parameter int FS_TAIL  = 1,
  parameter int FS_REST  = 1,
  parameter int BYTE_GAP = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_i,
  input  logic          split_i,
  input  logic          tmr_zero,
  input  logic          word_bit,
  output logic          word_load,
  output logic [SW-1:0] bit_sel,
  output logic          tmr_load,
  output logic [TW-1:0] tmr_val,
  output logic          busy_o,
  output logic          done_o,
  output logic          cs_n_o,
  output logic          fs_o,
  output logic          sclk_o,
  output logic          din_o
);
  import dacfrm_pkg::*;

  localparam int BYTE_BITS = WORD_W / 2;

  dac_st_e       state_q;
  logic [SW-1:0] bitn_q;
  logic          split_q;

  assign word_load = (state_q == ST_IDLE) && start_i;
  assign bit_sel   = (state_q == ST_LOW) ? bitn_q + 1'b1 : bitn_q;
  assign tmr_load  = (state_q == ST_IDLE) ? start_i : tmr_zero;

  always_comb begin
    tmr_val = '0;
    case (state_q)
      ST_IDLE: tmr_val = TW'(CS_LEAD - 1);
      ST_CSL:  tmr_val = TW'(FS_LEAD - 1);
      ST_FSL:  tmr_val = TW'(HALF_CYC - 1);
      ST_LOW:  tmr_val = (split_q && bitn_q == SW'(BYTE_BITS - 1))
                         ? TW'(HALF_CYC - 1 + BYTE_GAP) : TW'(HALF_CYC - 1);
      ST_HIGH: tmr_val = (bitn_q == SW'(WORD_W)) ? TW'(FS_TAIL - 1)
                                                  : TW'(HALF_CYC - 1);
      ST_TAIL: tmr_val = TW'(FS_REST - 1);
      default: tmr_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      bitn_q  <= '0;
      split_q <= 1'b0;
      busy_o  <= 1'b0;
      done_o  <= 1'b0;
      cs_n_o  <= 1'b1;
      fs_o    <= 1'b1;
      sclk_o  <= 1'b1;
      din_o   <= 1'b0;
    end else begin
      done_o <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            state_q <= ST_CSL;
            split_q <= split_i;
            bitn_q  <= '0;
            busy_o  <= 1'b1;
            cs_n_o  <= 1'b0;
          end
        end
        ST_CSL: begin
          if (tmr_zero) begin
            state_q <= ST_FSL;
            fs_o    <= 1'b0;
            din_o   <= word_bit;
          end
        end
        ST_FSL: begin
          if (tmr_zero) begin
            state_q <= ST_LOW;
            sclk_o  <= 1'b0;
          end
        end
        ST_LOW: begin
          if (tmr_zero) begin
            state_q <= ST_HIGH;
            sclk_o  <= 1'b1;
            bitn_q  <= bitn_q + 1'b1;
            din_o   <= word_bit;
          end
        end
        ST_HIGH: begin
          if (tmr_zero) begin
            if (bitn_q == SW'(WORD_W)) begin
              state_q <= ST_TAIL;
              fs_o    <= 1'b1;
            end else begin
              state_q <= ST_LOW;
              sclk_o  <= 1'b0;
            end
          end
        end
        ST_TAIL: begin
          if (tmr_zero) begin
            state_q <= ST_REST;
            cs_n_o  <= 1'b1;
          end
        end
        ST_REST: begin
          if (tmr_zero) begin
            state_q <= ST_IDLE;
            busy_o  <= 1'b0;
            done_o  <= 1'b1;
            bitn_q  <= '0;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/dacfrm_tx.sv
module dacfrm_tx #(
  parameter int CODE_W   = 10,
  parameter int HALF_CYC = 2,
  parameter int CS_LEAD  = 1,
  parameter int FS_LEAD  = 1,
  parameter int FS_TAIL  = 1,
  parameter int FS_REST  = 1,
  parameter int BYTE_GAP = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic              fast_i,
  input  logic              pdown_i,
  input  logic              split_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              cs_n_o,
  output logic              fs_o,
  output logic              sclk_o,
  output logic              din_o
);
  import dacfrm_pkg::*;

  localparam int WORD_W  = CTRL_BITS + CODE_W + PAD_BITS;
  localparam int SW      = $clog2(WORD_W + 1);
  localparam int TMR_MAX = max2(max2(HALF_CYC - 1 + BYTE_GAP, CS_LEAD),
                                max2(max2(FS_LEAD, FS_TAIL), FS_REST));
  localparam int TW      = max2(1, $clog2(TMR_MAX + 1));

  logic          word_load;
  logic [SW-1:0] bit_sel;
  logic          word_bit;
  logic          tmr_load;
  logic [TW-1:0] tmr_val;
  logic          tmr_zero;

  dacfrm_word #(.CODE_W(CODE_W), .WORD_W(WORD_W), .SW(SW)) word_i (
    .clk   (clk),
    .rst   (rst),
    .load  (word_load),
    .code  (code_i),
    .fast  (fast_i),
    .pdown (pdown_i),
    .sel   (bit_sel),
    .bit_o (word_bit)
  );

  dacfrm_timer #(.TW(TW)) tmr_i (
    .clk    (clk),
    .rst    (rst),
    .load   (tmr_load),
    .val    (tmr_val),
    .zero_o (tmr_zero)
  );

  dacfrm_fsm #(
    .WORD_W(WORD_W), .SW(SW), .TW(TW), .HALF_CYC(HALF_CYC),
    .CS_LEAD(CS_LEAD), .FS_LEAD(FS_LEAD), .FS_TAIL(FS_TAIL),
    .FS_REST(FS_REST), .BYTE_GAP(BYTE_GAP)
  ) fsm_i (
    .clk       (clk),
    .rst       (rst),
    .start_i   (start_i),
    .split_i   (split_i),
    .tmr_zero  (tmr_zero),
    .word_bit  (word_bit),
    .word_load (word_load),
    .bit_sel   (bit_sel),
    .tmr_load  (tmr_load),
    .tmr_val   (tmr_val),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .cs_n_o    (cs_n_o),
    .fs_o      (fs_o),
    .sclk_o    (sclk_o),
    .din_o     (din_o)
  );

endmodule

// File: rtl/dacfrm_tx_chk.sv
module dacfrm_tx_chk (
  input logic clk,
  input logic rst,
  input logic start_i,
  input logic busy_o,
  input logic done_o,
  input logic cs_n_o,
  input logic fs_o,
  input logic sclk_o,
  input logic din_o
);

  a_r2_idle_holds: assert property (@(posedge clk) disable iff (rst)
    (!busy_o && !start_i) |=> !busy_o);

  a_r4_fs_inside_cs: assert property (@(posedge clk) disable iff (rst)
    !fs_o |-> !cs_n_o);

  a_r6_sclk_idle_high: assert property (@(posedge clk) disable iff (rst)
    fs_o |-> sclk_o);

  a_r7_din_stable_low: assert property (@(posedge clk) disable iff (rst)
    (!sclk_o && $past(!sclk_o)) |-> $stable(din_o));

  a_r8_cs_rises_after_fs: assert property (@(posedge clk) disable iff (rst)
    $rose(cs_n_o) |-> fs_o);

  a_r10_done_single: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  a_r10_done_quiet: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (!busy_o && cs_n_o && fs_o && sclk_o));

endmodule

bind dacfrm_tx dacfrm_tx_chk chk_i (
  .clk     (clk),
  .rst     (rst),
  .start_i (start_i),
  .busy_o  (busy_o),
  .done_o  (done_o),
  .cs_n_o  (cs_n_o),
  .fs_o    (fs_o),
  .sclk_o  (sclk_o),
  .din_o   (din_o)
);

// File: tb/dacfrm_tx_tb_top.sv
module dacfrm_tx_tb_top;

  localparam int P_H = 2;
  localparam int P_A = 2;
  localparam int P_B = 3;
  localparam int P_T = 1;
  localparam int P_R = 2;
  localparam int P_G = 4;
  localparam int NFR = 1024;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start_i = 1'b0;
  logic [9:0] code_i = '0;
  logic       fast_i = 1'b0;
  logic       pdown_i = 1'b0;
  logic       split_i = 1'b0;
  logic       busy_o, done_o, cs_n_o, fs_o, sclk_o, din_o;

  always #10 clk = ~clk;

  dacfrm_tx #(
    .CODE_W(10), .HALF_CYC(P_H), .CS_LEAD(P_A), .FS_LEAD(P_B),
    .FS_TAIL(P_T), .FS_REST(P_R), .BYTE_GAP(P_G)
  ) dut_i (
    .clk(clk), .rst(rst), .start_i(start_i), .code_i(code_i),
    .fast_i(fast_i), .pdown_i(pdown_i), .split_i(split_i),
    .busy_o(busy_o), .done_o(done_o), .cs_n_o(cs_n_o), .fs_o(fs_o),
    .sclk_o(sclk_o), .din_o(din_o)
  );

  int n_chk = 0;
  int n_fail = 0;
  int done_cnt = 0;
  int n_started = 0;
  int n_csf = 0;
  logic [15:0] exp_w = '0;
  logic        exp_split = 1'b0;
  logic        finished = 1'b0;

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // pin monitor, sampled mid-cycle
  int cyc = 0;
  int t_csf, t_fsf, t_fall, t_rise, t_fsr, t_csr, nf;
  logic [15:0] cap;
  logic p_cs = 1'b1, p_fs = 1'b1, p_sclk = 1'b1, p_din = 1'b0, p_done = 1'b0;

  always @(negedge clk) begin
    cyc++;
    if (!rst) begin
      if (p_cs && !cs_n_o) begin
        t_csf = cyc; nf = 0; cap = '0; n_csf++;
        chk(busy_o == 1'b1, "R2 busy with cs fall", int'(busy_o), 1);
      end
      if (p_fs && !fs_o) begin
        t_fsf = cyc;
        chk(cyc - t_csf == P_A, "R4 cs-to-fs", cyc - t_csf, P_A);
      end
      if (!fs_o) chk(!cs_n_o, "R4 fs low inside cs", int'(cs_n_o), 0);
      if (din_o != p_din)
        chk((!p_sclk && sclk_o) || (p_fs && !fs_o), "R7 din edge", int'(sclk_o), 1);
      if (p_sclk && !sclk_o) begin
        if (nf == 0)
          chk(cyc - t_fsf == P_B, "R5 fs-to-first-fall", cyc - t_fsf, P_B);
        else if (exp_split && nf == 8)
          chk(cyc - t_rise == P_H + P_G, "R9 byte gap", cyc - t_rise, P_H + P_G);
        else
          chk(cyc - t_rise == P_H, "R6 high phase", cyc - t_rise, P_H);
        if (exp_split && nf == 8)
          chk(!fs_o && !cs_n_o, "R9 frame held", int'(fs_o), 0);
        cap = {cap[14:0], din_o};
        nf++;
        t_fall = cyc;
      end
      if (!p_sclk && sclk_o) begin
        chk(cyc - t_fall == P_H, "R6 low phase", cyc - t_fall, P_H);
        chk(p_din == cap[0], "R7 din held in low phase", int'(p_din), int'(cap[0]));
        t_rise = cyc;
      end
      if (!p_fs && fs_o) begin
        t_fsr = cyc;
        chk(nf == 16, "R6 fall count", nf, 16);
        chk(cyc - t_rise == P_H, "R8 last rise to fs", cyc - t_rise, P_H);
        chk(cap == exp_w, "R3 word", int'(cap), int'(exp_w));
      end
      if (fs_o) chk(sclk_o, "R6 sclk idle high", int'(sclk_o), 1);
      if (!p_cs && cs_n_o) begin
        t_csr = cyc;
        chk(cyc - t_fsr == P_T, "R8 fs-to-cs", cyc - t_fsr, P_T);
        chk(fs_o, "R8 fs high at cs rise", int'(fs_o), 1);
      end
      if (p_done)
        chk(!done_o, "R10 done one cycle", int'(done_o), 0);
      if (done_o) begin
        chk(cyc - t_csr == P_R, "R10 cs-to-done", cyc - t_csr, P_R);
        chk(!busy_o, "R10 busy falls with done", int'(busy_o), 0);
        chk(n_csf == n_started, "R2 frame count", n_csf, n_started);
        done_cnt++;
      end
    end
    p_cs = cs_n_o; p_fs = fs_o; p_sclk = sclk_o; p_din = din_o; p_done = done_o;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(cs_n_o && fs_o && sclk_o && !din_o && !busy_o && !done_o,
        "R1 reset state", {cs_n_o, fs_o, sclk_o, din_o, busy_o, done_o}, 6'b111000);
    rst = 1'b0;
    @(negedge clk);
    chk(cs_n_o && fs_o && sclk_o && !din_o && !busy_o && !done_o,
        "R1 after reset", {cs_n_o, fs_o, sclk_o, din_o, busy_o, done_o}, 6'b111000);
    for (int i = 0; i < NFR; i++) begin
      logic [9:0] c;
      logic f, p, s;
      c = 10'(i * 37 + 5);
      if (i < 4) c = (i[0]) ? 10'h3FF : 10'h000;
      f = c[0] ^ 1'(i >> 4);
      p = 1'(i >> 1);
      s = 1'(i >> 2) ^ 1'(i >> 7);
      start_i = 1'b1; code_i = c; fast_i = f; pdown_i = p; split_i = s;
      exp_w = {1'b0, f, p, 1'b0, c, 2'b00};
      exp_split = s;
      n_started++;
      @(negedge clk);
      start_i = 1'b0;
      if (i % 37 == 5) begin
        repeat (20) @(negedge clk);
        start_i = 1'b1; code_i = ~c; fast_i = ~f; pdown_i = ~p; split_i = ~s;
        @(negedge clk);
        start_i = 1'b0;
      end
      wait (done_cnt == i + 1);
      // even frames: next start lands in the done cycle
      if (i % 2 == 1) repeat (3) @(negedge clk);
    end
    repeat (5) @(negedge clk);
    chk(!busy_o && cs_n_o, "R2 no stray frame", int'(busy_o), 0);
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d frames", done_cnt, NFR);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule